// File: doc/BRIEF.md
# SD Card SPI Single-Block Data Engine

This block carries one data block between a local byte buffer and an SD card in SPI mode. It runs only after the command that opens the transfer has been issued and accepted elsewhere. The block never drives the serial wires itself. It requests one byte exchange at a time from a byte-level SPI shifter, supplies the byte to transmit, and takes back the byte received in the same exchange.

A read polls the card until the single-block start token 0xFE arrives, or until a poll budget runs out. It then stores the block into the buffer and discards the two CRC bytes. A write sends the gap bytes, the start token, the block taken from the buffer and two CRC filler bytes. It then decodes the card's data-response token and polls until the card leaves the busy state. A one-cycle done pulse ends each transfer, and a status code holds the outcome until the next transfer ends. The block also maps the logical block number latched at start into the card address, and gives the address of the following block. Standard-capacity cards are addressed by byte; high-capacity cards by block.

Top module: `sd_blk_engine`

## Requirements
- R1: After reset, busy_o, done_o and xfer_req_o are 0 and status_o is 0 (ok).
- R2: A read polls one exchange at a time. Every byte received before the first 0xFE is discarded, and the 0xFE itself is not stored.
- R3: Once the token has arrived, a read stores exactly 512 received bytes at buffer indexes 0 to 511 in arrival order. It then performs 2 more exchanges without writing the buffer, and ends with status 0 (ok).
- R4: If TOKEN_TRIES exchanges in a row return no 0xFE, a read ends with status 1 (timeout) after exactly TOKEN_TRIES exchanges and writes nothing to the buffer. A token on the last allowed exchange still succeeds.
- R5: A write transmits, in order: GAP_BYTES bytes of 0xFF, the token 0xFE, the 512 buffer bytes at indexes 0 to 511, and 2 bytes of 0xFF.
- R6: The byte received right after the CRC filler is the response. Its low 5 bits (the byte ANDed with 0x1F) decode as follows: 0x05 accepted; 0x0B gives status 2 (crc error); 0x0D gives status 3 (write error); any other value gives status 4 (general error). An error ends the transfer with no further exchange.
- R7: After an accepted response, a write polls until a 0xFF is received and then ends with status 0 (ok). If BUSY_TRIES polls in a row see no 0xFF, it ends with status 1 (timeout) after exactly BUSY_TRIES polls.
- R8: card_addr_o equals blk × 512 when hc is 0 and blk when hc is 1, where blk and hc are the values latched at start. next_addr_o equals card_addr_o + 512 when hc is 0 and card_addr_o + 1 when hc is 1.
- R9: done_o is a single-cycle pulse, one per transfer. busy_o is high from the cycle after start until the cycle after done_o. A start_i while busy_o is high is ignored and changes neither the latched address nor the transfer in progress.
- R10: Every byte transmitted during a read is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a transfer; sampled only while idle |
| wr_i | input | 1 | Direction: 1 write to card, 0 read from card |
| hc_i | input | 1 | Card is high-capacity (block addressed) |
| blk_i | input | AW | Logical block number |
| card_addr_o | output | AW | Card address of the latched block |
| next_addr_o | output | AW | Card address of the following block |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| status_o | output | 3 | 0 ok, 1 timeout, 2 crc error, 3 write error, 4 general error |
| xfer_req_o | output | 1 | Byte exchange request, held until acknowledged |
| xfer_tx_o | output | 8 | Byte to transmit |
| xfer_ack_i | input | 1 | Exchange complete; xfer_rx_i valid |
| xfer_rx_i | input | 8 | Byte received |
| buf_idx_o | output | 9 | Buffer byte index |
| buf_we_o | output | 1 | Buffer write strobe (read transfers) |
| buf_wdata_o | output | 8 | Byte to store in the buffer |
| buf_rdata_i | input | 8 | Buffer byte at buf_idx_o (combinational read) |

## Verification
The engine raises a new request on the clock edge after each acknowledge. The card model answers on the following falling edge, so every exchange takes two cycles. The model logs the transmitted byte and the buffer strobe at the acknowledging edge rather than counting cycles. The address outputs are due one edge after start is sampled and are checked on the falling edge after start is dropped. done_o rises on the edge that consumes the last exchange and busy_o falls one edge later. The bench therefore samples status on the falling edge where done_o is first seen, and checks busy_o on the next falling edge.

// File: rtl/sd_blk_pkg.sv
package sd_blk_pkg;
  typedef enum logic [2:0] {
    ST_OK      = 3'd0,
    ST_TIMEOUT = 3'd1,
    ST_CRC_ERR = 3'd2,
    ST_WR_ERR  = 3'd3,
    ST_GEN_ERR = 3'd4
  } blk_status_e;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_TOK, S_RD_DAT, S_RD_CRC,
    S_WR_GAP, S_WR_TOK, S_WR_DAT, S_WR_CRC, S_WR_RSP, S_WR_BSY,
    S_DONE
  } eng_state_e;

  localparam logic [7:0] TOKEN_START = 8'hFE;
  localparam logic [7:0] BYTE_IDLE   = 8'hFF;
  localparam logic [4:0] RSP_ACCEPT  = 5'h05;
  localparam logic [4:0] RSP_CRC     = 5'h0B;
  localparam logic [4:0] RSP_WRITE   = 5'h0D;
endpackage

// File: rtl/sd_blk_addr.sv
module sd_blk_addr #(
  parameter int AW       = 32,
  parameter int BLK_LOG2 = 9
) (
  input  logic [AW-1:0] blk_i,
  input  logic          hc_i,
  output logic [AW-1:0] addr_o,
  output logic [AW-1:0] next_o
);
  localparam logic [AW-1:0] BYTE_STEP = AW'(1) << BLK_LOG2;

  always_comb begin
    addr_o = hc_i ? blk_i : (blk_i << BLK_LOG2);
    next_o = addr_o + (hc_i ? AW'(1) : BYTE_STEP);
  end
endmodule

// File: rtl/sd_blk_resp_dec.sv
module sd_blk_resp_dec
  import sd_blk_pkg::*;
(
  input  logic [7:0]  rx_i,
  output logic        accept_o,
  output blk_status_e code_o
);
  logic [4:0] tok;
  assign tok = rx_i[4:0];

  always_comb begin
    accept_o = 1'b0;
    unique case (tok)
      RSP_ACCEPT: begin accept_o = 1'b1; code_o = ST_OK; end
      RSP_CRC:    code_o = ST_CRC_ERR;
      RSP_WRITE:  code_o = ST_WR_ERR;
      default:    code_o = ST_GEN_ERR;
    endcase
  end
endmodule

// File: rtl/sd_blk_poll_timer.sv
module sd_blk_poll_timer #(
  parameter int TRIES = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic step_i,
  output logic last_o
);
  localparam int CW = $clog2(TRIES + 1);
  localparam logic [CW-1:0] LAST = CW'(TRIES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (step_i) cnt_q <= cnt_q + CW'(1);
  end

  // current poll is the final one allowed
  assign last_o = (cnt_q == LAST);
endmodule

// File: rtl/sd_blk_engine.sv
module sd_blk_engine
  import sd_blk_pkg::*;
#(
  parameter int AW          = 32,
  parameter int BLK_LOG2    = 9,
  parameter int GAP_BYTES   = 2,
  parameter int CRC_BYTES   = 2,
  parameter int TOKEN_TRIES = 4096,
  parameter int BUSY_TRIES  = 65536
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                wr_i,
  input  logic                hc_i,
  input  logic [AW-1:0]       blk_i,
  output logic [AW-1:0]       card_addr_o,
  output logic [AW-1:0]       next_addr_o,
  output logic                busy_o,
  output logic                done_o,
  output logic [2:0]          status_o,
  output logic                xfer_req_o,
  output logic [7:0]          xfer_tx_o,
  input  logic                xfer_ack_i,
  input  logic [7:0]          xfer_rx_i,
  output logic [BLK_LOG2-1:0] buf_idx_o,
  output logic                buf_we_o,
  output logic [7:0]          buf_wdata_o,
  input  logic [7:0]          buf_rdata_i
);
  localparam int IW = BLK_LOG2;
  localparam logic [IW-1:0] LAST_DAT = IW'((1 << BLK_LOG2) - 1);
  localparam logic [IW-1:0] LAST_GAP = IW'(GAP_BYTES - 1);
  localparam logic [IW-1:0] LAST_CRC = IW'(CRC_BYTES - 1);

  eng_state_e  state_q;
  blk_status_e status_q;
  logic [IW-1:0] cnt_q;
  logic          req_q;
  logic [7:0]    tx_q;
  logic          wr_q, hc_q;
  logic [AW-1:0] blk_q;

  logic        got;
  logic        tok_last, bsy_last;
  logic        rsp_accept;
  blk_status_e rsp_code;
  logic [7:0]  tx_sel;

  assign got = req_q & xfer_ack_i;

  sd_blk_addr #(.AW(AW), .BLK_LOG2(BLK_LOG2)) u_addr (
    .blk_i (blk_q),
    .hc_i  (hc_q),
    .addr_o(card_addr_o),
    .next_o(next_addr_o)
  );

  sd_blk_resp_dec u_dec (
    .rx_i    (xfer_rx_i),
    .accept_o(rsp_accept),
    .code_o  (rsp_code)
  );

  sd_blk_poll_timer #(.TRIES(TOKEN_TRIES)) u_tok_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (state_q != S_RD_TOK),
    .step_i(got && (state_q == S_RD_TOK) && (xfer_rx_i != TOKEN_START)),
    .last_o(tok_last)
  );

  sd_blk_poll_timer #(.TRIES(BUSY_TRIES)) u_bsy_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (state_q != S_WR_BSY),
    .step_i(got && (state_q == S_WR_BSY) && (xfer_rx_i != BYTE_IDLE)),
    .last_o(bsy_last)
  );

  always_comb begin
    unique case (state_q)
      S_WR_TOK: tx_sel = TOKEN_START;
      S_WR_DAT: tx_sel = buf_rdata_i;
      default:  tx_sel = BYTE_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      status_q <= ST_OK;
      cnt_q    <= '0;
      req_q    <= 1'b0;
      tx_q     <= BYTE_IDLE;
      wr_q     <= 1'b0;
      hc_q     <= 1'b0;
      blk_q    <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          if (start_i) begin
            wr_q    <= wr_i;
            hc_q    <= hc_i;
            blk_q   <= blk_i;
            cnt_q   <= '0;
            state_q <= wr_i ? S_WR_GAP : S_RD_TOK;
          end
        end
        S_DONE: state_q <= S_IDLE;
        default: begin
          if (!req_q) begin
            req_q <= 1'b1;
            tx_q  <= tx_sel;
          end else if (xfer_ack_i) begin
            req_q <= 1'b0;
            unique case (state_q)
              S_RD_TOK: begin
                if (xfer_rx_i == TOKEN_START) begin
                  state_q <= S_RD_DAT;
                  cnt_q   <= '0;
                end else if (tok_last) begin
                  status_q <= ST_TIMEOUT;
                  state_q  <= S_DONE;
                end
              end
              S_RD_DAT, S_WR_DAT: begin
                if (cnt_q == LAST_DAT) begin
                  cnt_q   <= '0;
                  state_q <= (state_q == S_RD_DAT) ? S_RD_CRC : S_WR_CRC;
                end else cnt_q <= cnt_q + IW'(1);
              end
              S_RD_CRC: begin
                if (cnt_q == LAST_CRC) begin
                  status_q <= ST_OK;
                  state_q  <= S_DONE;
                end else cnt_q <= cnt_q + IW'(1);
              end
              S_WR_GAP: begin
                if (cnt_q == LAST_GAP) begin
                  cnt_q   <= '0;
                  state_q <= S_WR_TOK;
                end else cnt_q <= cnt_q + IW'(1);
              end
              S_WR_TOK: state_q <= S_WR_DAT;
              S_WR_CRC: begin
                if (cnt_q == LAST_CRC) state_q <= S_WR_RSP;
                else cnt_q <= cnt_q + IW'(1);
              end
              S_WR_RSP: begin
                if (rsp_accept) state_q <= S_WR_BSY;
                else begin
                  status_q <= rsp_code;
                  state_q  <= S_DONE;
                end
              end
              S_WR_BSY: begin
                if (xfer_rx_i == BYTE_IDLE) begin
                  status_q <= ST_OK;
                  state_q  <= S_DONE;
                end else if (bsy_last) begin
                  status_q <= ST_TIMEOUT;
                  state_q  <= S_DONE;
                end
              end
              default: state_q <= S_IDLE;
            endcase
          end
        end
      endcase
    end
  end

  assign busy_o      = (state_q != S_IDLE);
  assign done_o      = (state_q == S_DONE);
  assign status_o    = status_q;
  assign xfer_req_o  = req_q;
  assign xfer_tx_o   = tx_q;
  assign buf_idx_o   = cnt_q;
  assign buf_we_o    = got && (state_q == S_RD_DAT);
  assign buf_wdata_o = xfer_rx_i;
endmodule

module sd_blk_engine_chk #(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          xfer_req_o,
  input logic [7:0]    xfer_tx_o,
  input logic          xfer_ack_i,
  input logic          buf_we_o,
  input logic [AW-1:0] card_addr_o,
  input logic          wr_q,
  input logic          hc_q
);
  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R9
  busy_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
  // R9
  start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(card_addr_o));
  // R10
  read_tx_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !wr_q && xfer_req_o) |-> (xfer_tx_o == 8'hFF));
  // R3
  buf_we_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_we_o |-> (busy_o && !wr_q));
  // R5
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_req_o && !xfer_ack_i) |=> (xfer_req_o && $stable(xfer_tx_o)));
  // R8
  byte_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !hc_q) |-> (card_addr_o[8:0] == 9'd0));
endmodule

bind sd_blk_engine sd_blk_engine_chk #(.AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .xfer_req_o (xfer_req_o),
  .xfer_tx_o  (xfer_tx_o),
  .xfer_ack_i (xfer_ack_i),
  .buf_we_o   (buf_we_o),
  .card_addr_o(card_addr_o),
  .wr_q       (wr_q),
  .hc_q       (hc_q)
);

// File: tb/sim_sd_blk_engine.sv
module sim_sd_blk_engine;
  localparam int AW = 32;
  localparam int TT = 16;
  localparam int BT = 32;
  localparam int QN = 1200;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, wr_i = 1'b0, hc_i = 1'b0;
  logic [AW-1:0] blk_i = '0;
  logic [AW-1:0] card_addr_o, next_addr_o;
  logic busy_o, done_o;
  logic [2:0] status_o;
  logic xfer_req_o;
  logic [7:0] xfer_tx_o;
  logic xfer_ack_i = 1'b0;
  logic [7:0] xfer_rx_i = 8'hFF;
  logic [8:0] buf_idx_o;
  logic buf_we_o;
  logic [7:0] buf_wdata_o, buf_rdata_i;

  always #10 clk_i = ~clk_i;

  sd_blk_engine #(.AW(AW), .TOKEN_TRIES(TT), .BUSY_TRIES(BT)) u0 (.*);

  logic [7:0] mem [0:511];
  logic [7:0] rdbuf [0:511];
  logic [7:0] rsp_q [0:QN-1];
  logic [7:0] tx_log [0:QN-1];
  int rsp_n, xn, wn, dn;
  int n_chk = 0, n_bad = 0;
  bit wrong_order;

  assign buf_rdata_i = mem[buf_idx_o];

  // card model: answers one request per two cycles
  always @(negedge clk_i) begin
    if (xfer_ack_i) xfer_ack_i <= 1'b0;
    else if (xfer_req_o) begin
      xfer_rx_i <= (xn < rsp_n) ? rsp_q[xn] : 8'hFF;
      if (xn < QN) tx_log[xn] <= xfer_tx_o;
      xn <= xn + 1;
      xfer_ack_i <= 1'b1;
    end
  end

  always @(posedge clk_i) begin
    if (buf_we_o) begin
      if (buf_idx_o != 9'(wn)) wrong_order = 1'b1;
      rdbuf[buf_idx_o] <= buf_wdata_o;
      wn <= wn + 1;
    end
    if (done_o) dn <= dn + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_card();
    @(negedge clk_i);
    rsp_n = 0; xn = 0; wn = 0; dn = 0; wrong_order = 1'b0;
  endtask

  task automatic push(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin rsp_q[rsp_n] = b; rsp_n++; end
  endtask

  task automatic kick(input bit wr, input bit hc, input int blk);
    @(negedge clk_i);
    start_i = 1'b1; wr_i = wr; hc_i = hc; blk_i = AW'(blk);
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic wait_done(input string req, input int exp_status);
    int t;
    t = 0;
    while (!done_o && t < 20000) begin @(negedge clk_i); t++; end
    chk(done_o == 1'b1, req, done_o, 1);
    chk(status_o == 3'(exp_status), req, status_o, exp_status);
    @(negedge clk_i);
    chk(busy_o == 1'b0 && done_o == 1'b0, "R9", busy_o, 0);
    chk(dn == 1, "R9", dn, 1);
  endtask

  task automatic t_read_ok();
    bit bad;
    clear_card();
    push(8'hFF, 3); push(8'h3C, 1); push(8'hFE, 1);
    for (int i = 0; i < 512; i++) push(8'((i * 7 + 3) & 8'hFF), 1);
    push(8'hFE, 2);
    kick(1'b0, 1'b0, 5);
    // R8 byte addressing
    chk(card_addr_o == 32'd2560, "R8", card_addr_o, 2560);
    chk(next_addr_o == 32'd3072, "R8", next_addr_o, 3072);
    wait_done("R3", 0);
    chk(xn == 5 + 512 + 2, "R2", xn, 519);
    chk(wn == 512 && !wrong_order, "R3", wn, 512);
    bad = 1'b0;
    for (int i = 0; i < 512; i++) if (rdbuf[i] != 8'((i * 7 + 3) & 8'hFF)) bad = 1'b1;
    chk(!bad, "R3", bad, 0);
    bad = 1'b0;
    for (int i = 0; i < 519; i++) if (tx_log[i] != 8'hFF) bad = 1'b1;
    chk(!bad, "R10", bad, 0);
  endtask

  task automatic t_read_last_try();
    clear_card();
    push(8'hFF, TT - 1); push(8'hFE, 1);
    for (int i = 0; i < 514; i++) push(8'h11, 1);
    kick(1'b0, 1'b1, 5);
    chk(card_addr_o == 32'd5, "R8", card_addr_o, 5);
    chk(next_addr_o == 32'd6, "R8", next_addr_o, 6);
    wait_done("R4", 0);
    chk(wn == 512, "R4", wn, 512);
  endtask

  task automatic t_read_timeout();
    clear_card();
    kick(1'b0, 1'b0, 1);
    wait_done("R4", 1);
    chk(xn == TT, "R4", xn, TT);
    chk(wn == 0, "R4", wn, 0);
  endtask

  task automatic t_read_ignore_start();
    clear_card();
    push(8'hFE, 1);
    for (int i = 0; i < 514; i++) push(8'h22, 1);
    kick(1'b0, 1'b0, 7);
    repeat (20) @(negedge clk_i);
    start_i = 1'b1; wr_i = 1'b1; hc_i = 1'b1; blk_i = 32'd99;
    @(negedge clk_i);
    start_i = 1'b0;
    @(negedge clk_i);
    chk(card_addr_o == 32'd3584, "R9", card_addr_o, 3584);
    wait_done("R9", 0);
    chk(xn == 515 && wn == 512, "R9", xn, 515);
  endtask

  task automatic t_write(input logic [7:0] rsp, input int busy_n, input int exp_st,
                         input int exp_xn, input string req);
    bit bad;
    clear_card();
    push(8'hFF, 2 + 1 + 512 + 2);
    push(rsp, 1);
    push(8'h00, busy_n);
    kick(1'b1, 1'b1, 40);
    wait_done(req, exp_st);
    chk(xn == exp_xn, req, xn, exp_xn);
    chk(wn == 0, "R5", wn, 0);
    bad = 1'b0;
    if (tx_log[0] != 8'hFF || tx_log[1] != 8'hFF || tx_log[2] != 8'hFE) bad = 1'b1;
    for (int i = 0; i < 512; i++) if (tx_log[3 + i] != mem[i]) bad = 1'b1;
    if (tx_log[515] != 8'hFF || tx_log[516] != 8'hFF) bad = 1'b1;
    chk(!bad, "R5", bad, 0);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = 8'(i) ^ 8'h5A ^ 8'(i >> 8);
    rsp_n = 0; xn = 0; wn = 0; dn = 0;
    repeat (3) @(negedge clk_i);
    // R1
    chk(busy_o == 0 && done_o == 0 && xfer_req_o == 0, "R1", busy_o, 0);
    chk(status_o == 3'd0, "R1", status_o, 0);
    rst_ni = 1'b1;
    t_read_ok();
    t_read_last_try();
    t_read_timeout();
    t_read_ignore_start();
    // R7 accepted, busy for 4 polls then ready
    t_write(8'hE5, 4, 0, 518 + 5, "R7");
    // R6 error codes, no busy polling
    t_write(8'hEB, 4, 2, 518, "R6");
    t_write(8'h2D, 4, 3, 518, "R6");
    t_write(8'h07, 4, 4, 518, "R6");
    // R7 busy never clears
    t_write(8'h05, BT + 8, 1, 518 + BT, "R7");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule